// File: doc/BRIEF.md
# Temporal Redundancy Fault Controller

This controller sits around a small linear array of identical processing elements. It protects each block of work with redundancy in time rather than in extra hardware. Every accepted block is evaluated three times. The first two evaluations use the straight element mapping, so lane i runs on element i. The third evaluation shifts the lanes onto the elements by a fixed rotation. Each element adds its lane input word to that lane's stored array state, modulo 2^DW.

When the two straight passes disagree, the fault is taken to be transient. The controller restores the array state from checkpoint memory and returns to idle, and the host then replays the blocks issued since that checkpoint. When the straight passes agree but the rotated pass differs, the same element has given the same wrong answer twice. The controller treats this as a persistent configuration fault and raises a reconfiguration request. Once the request is acknowledged, it rolls back.

Results of the first pass leave through a stream port while the later passes and comparisons run. They are final only when the commit strobe fires, and a retract pulse tells downstream logic to drop them. A fault-injection input can flip bits in one element's output for a single cycle or hold that output at a stuck value.

The state machine has these states: IDLE, PASS1, PASS2, COMPARE12, PASS3, COMPARE3, ROLLBACK, RECONFIG_WAIT and COMMIT. Its transitions are:
- IDLE→PASS1 on start.
- PASS1→PASS2→COMPARE12 unconditionally.
- COMPARE12→PASS3 on agreement, →ROLLBACK on disagreement, or →RECONFIG_WAIT on disagreement once the retry budget is spent.
- PASS3→COMPARE3.
- COMPARE3→COMMIT on agreement, →RECONFIG_WAIT otherwise.
- RECONFIG_WAIT→ROLLBACK on acknowledge.
- ROLLBACK→IDLE.
- COMMIT→IDLE once the result stream has finished.

Top module: `temporal_fault_ctrl`

## Requirements
- R1: While reset is held and right after it, the status shows IDLE and res_valid, commit, retract, reconfig_req and ckpt_we are all low.
- R2: start is accepted only in IDLE. It captures blk_data, with lane i at bits [i*DW +: DW]. A start pulse in any other state changes neither the state sequence nor the captured block.
- R3: fsm_status is one-hot with bit 0 IDLE, 1 PASS1, 2 PASS2, 3 COMPARE12, 4 PASS3, 5 COMPARE3, 6 ROLLBACK, 7 RECONFIG_WAIT, 8 COMMIT. A fault-free block goes IDLE, PASS1, PASS2, COMPARE12, PASS3, COMPARE3, COMMIT, IDLE, one cycle per state.
- R4: The result of lane i is the lane-i input word plus the lane-i array state, modulo 2^DW.
- R5: First-pass results stream out in logical lane order, one word per cycle. res_idx runs 0 to N_PE-1, starting in the PASS2 cycle, and res_valid is low outside that stream.
- R6: commit is a one-cycle pulse in COMMIT, issued only after the stream has ended. The array state then takes the committed results.
- R7: A disagreement between passes 1 and 2 leads to a single ROLLBACK cycle with retract high. That cycle loads the array state from ckpt_rdata, and the controller then returns to IDLE.
- R8: A disagreement between pass 3 and pass 1 leads to RECONFIG_WAIT. reconfig_req stays high until reconfig_ack, and a ROLLBACK cycle follows.
- R9: After three consecutive transient rollbacks with no commit in between, the fourth pass-1/pass-2 disagreement goes to RECONFIG_WAIT instead. The count clears on commit and on entry to RECONFIG_WAIT.
- R10: ckpt_we fires in every CKPT_EVERY-th commit cycle, with ckpt_wdata equal to the committed results. The commit count restarts from zero at each rollback, and ckpt_we is never high without commit.
- R11: Pass 3 places lane i on physical element (i+ROT) mod N_PE while still storing results by logical lane. A stuck element therefore shows up as a persistent fault.
- R12: inj_pulse XORs inj_val into the output of physical element inj_pe during that cycle only. inj_stuck forces that output to inj_val for as long as it is held.
- R13: commit and retract are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a block (taken in IDLE only) |
| blk_data | input | N_PE*DW | Block input words, lane i at [i*DW +: DW] |
| res_valid | output | 1 | Result stream word valid |
| res_idx | output | $clog2(N_PE) | Logical lane of the streamed word |
| res_data | output | DW | Streamed first-pass result |
| commit | output | 1 | Streamed results of this block are final |
| retract | output | 1 | Discard uncommitted streamed results |
| ckpt_we | output | 1 | Checkpoint memory write strobe |
| ckpt_wdata | output | N_PE*DW | Array state to store |
| ckpt_rdata | input | N_PE*DW | Stored checkpoint read back on rollback |
| inj_pulse | input | 1 | One-cycle XOR corruption enable |
| inj_stuck | input | 1 | Stuck-value corruption enable |
| inj_pe | input | $clog2(N_PE) | Physical element to corrupt |
| inj_val | input | DW | XOR mask or stuck value |
| reconfig_req | output | 1 | Persistent fault: reconfiguration needed |
| reconfig_ack | input | 1 | Reconfiguration finished |
| fsm_status | output | 9 | One-hot controller state |

## Verification
The bound assertions hold on every cycle the following properties:
- fsm_status stays one-hot.
- Accepted starts enter PASS1, and PASS1 always moves to PASS2.
- retract appears only in ROLLBACK and is followed by IDLE.
- reconfig_req holds until acknowledged.
- Checkpoint writes occur only with commit, and commit is never paired with retract.

The bench's scenarios are the only way to show the other behaviours: the stored array state and checkpoint restore, transient versus persistent classification, the retry escalation count, checkpoint cadence, stream ordering and values, and the fact that a late start is ignored.

// File: rtl/tfc_pkg.sv
package tfc_pkg;

    typedef enum logic [3:0] {
        S_IDLE     = 4'd0,
        S_PASS1    = 4'd1,
        S_PASS2    = 4'd2,
        S_CMP12    = 4'd3,
        S_PASS3    = 4'd4,
        S_CMP3     = 4'd5,
        S_ROLLBACK = 4'd6,
        S_RECFG    = 4'd7,
        S_COMMIT   = 4'd8
    } tfc_state_e;

    localparam int unsigned TFC_NUM_STATES = 9;

endpackage

// File: rtl/tfc_pe.sv
module tfc_pe #(
    parameter int unsigned DW = 8
) (
    input  logic [DW-1:0] opnd_in,
    input  logic [DW-1:0] opnd_st,
    input  logic          pulse_hit,
    input  logic          stuck_hit,
    input  logic [DW-1:0] fault_val,
    output logic [DW-1:0] y
);
    logic [DW-1:0] sum;

    always_comb begin
        sum = opnd_in + opnd_st;
        if (stuck_hit) begin
            y = fault_val;
        end else if (pulse_hit) begin
            y = sum ^ fault_val;
        end else begin
            y = sum;
        end
    end
endmodule

// File: rtl/tfc_lane_map.sv
module tfc_lane_map #(
    parameter int unsigned N_PE = 4,
    parameter int unsigned DW   = 8,
    parameter int unsigned ROT  = 1,
    localparam int unsigned IW  = $clog2(N_PE),
    localparam int unsigned VW  = N_PE * DW
) (
    input  logic [VW-1:0] lane_in,
    input  logic [VW-1:0] lane_st,
    input  logic          rotate,
    input  logic          inj_pulse,
    input  logic          inj_stuck,
    input  logic [IW-1:0] inj_pe,
    input  logic [DW-1:0] inj_val,
    output logic [VW-1:0] lane_out
);
    localparam int unsigned ROT_M = ROT % N_PE;

    logic [DW-1:0] in_w  [N_PE];
    logic [DW-1:0] st_w  [N_PE];
    logic [DW-1:0] phy_y [N_PE];

    for (genvar l = 0; l < N_PE; l++) begin : g_unpack
        assign in_w[l] = lane_in[l*DW +: DW];
        assign st_w[l] = lane_st[l*DW +: DW];
    end

    for (genvar p = 0; p < N_PE; p++) begin : g_phys
        localparam int unsigned SRC_ROT = (p + N_PE - ROT_M) % N_PE;
        logic [IW-1:0] src;
        logic          hit;
        assign src = rotate ? IW'(SRC_ROT) : IW'(p);
        assign hit = (inj_pe == IW'(p));
        tfc_pe #(.DW(DW)) u_pe (
            .opnd_in   (in_w[src]),
            .opnd_st   (st_w[src]),
            .pulse_hit (inj_pulse && hit),
            .stuck_hit (inj_stuck && hit),
            .fault_val (inj_val),
            .y         (phy_y[p])
        );
    end

    for (genvar i = 0; i < N_PE; i++) begin : g_lane
        localparam int unsigned DST_ROT = (i + ROT_M) % N_PE;
        assign lane_out[i*DW +: DW] = phy_y[rotate ? IW'(DST_ROT) : IW'(i)];
    end
endmodule

// File: rtl/tfc_cmp.sv
module tfc_cmp #(
    parameter int unsigned N_PE = 4,
    parameter int unsigned DW   = 8,
    localparam int unsigned VW  = N_PE * DW
) (
    input  logic [VW-1:0] set_a,
    input  logic [VW-1:0] set_b,
    output logic          match
);
    logic [N_PE-1:0] lane_eq;

    for (genvar i = 0; i < N_PE; i++) begin : g_eq
        assign lane_eq[i] = (set_a[i*DW +: DW] == set_b[i*DW +: DW]);
    end

    assign match = &lane_eq;
endmodule

// File: rtl/temporal_fault_ctrl.sv
module temporal_fault_ctrl
    import tfc_pkg::*;
#(
    parameter int unsigned N_PE       = 4,
    parameter int unsigned DW         = 8,
    parameter int unsigned ROT        = 1,
    parameter int unsigned CKPT_EVERY = 2,
    parameter int unsigned MAX_RETRY  = 3,
    localparam int unsigned IW        = $clog2(N_PE),
    localparam int unsigned VW        = N_PE * DW
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [VW-1:0]             blk_data,
    output logic                      res_valid,
    output logic [IW-1:0]             res_idx,
    output logic [DW-1:0]             res_data,
    output logic                      commit,
    output logic                      retract,
    output logic                      ckpt_we,
    output logic [VW-1:0]             ckpt_wdata,
    input  logic [VW-1:0]             ckpt_rdata,
    input  logic                      inj_pulse,
    input  logic                      inj_stuck,
    input  logic [IW-1:0]             inj_pe,
    input  logic [DW-1:0]             inj_val,
    output logic                      reconfig_req,
    input  logic                      reconfig_ack,
    output logic [TFC_NUM_STATES-1:0] fsm_status
);
    localparam int unsigned RW  = $clog2(MAX_RETRY + 1);
    localparam int unsigned CKW = $clog2(CKPT_EVERY + 1);

    tfc_state_e    cur, nxt;
    logic [VW-1:0] in_q, st_q, res1_q, res2_q, res3_q, pass_res;
    logic          draining;
    logic [IW-1:0] drain_idx;
    logic [RW-1:0] retry_q;
    logic [CKW-1:0] ckcnt_q;
    logic          eq12, eq13, commit_now;

    tfc_lane_map #(.N_PE(N_PE), .DW(DW), .ROT(ROT)) u_map (
        .lane_in   (in_q),
        .lane_st   (st_q),
        .rotate    (cur == S_PASS3),
        .inj_pulse (inj_pulse),
        .inj_stuck (inj_stuck),
        .inj_pe    (inj_pe),
        .inj_val   (inj_val),
        .lane_out  (pass_res)
    );

    tfc_cmp #(.N_PE(N_PE), .DW(DW)) u_cmp12 (.set_a(res1_q), .set_b(res2_q), .match(eq12));
    tfc_cmp #(.N_PE(N_PE), .DW(DW)) u_cmp13 (.set_a(res1_q), .set_b(res3_q), .match(eq13));

    assign commit_now = (cur == S_COMMIT) && !draining;

    always_comb begin
        nxt = cur;
        unique case (cur)
            S_IDLE:     if (start) nxt = S_PASS1;
            S_PASS1:    nxt = S_PASS2;
            S_PASS2:    nxt = S_CMP12;
            S_CMP12: begin
                if (eq12)                         nxt = S_PASS3;
                else if (retry_q == RW'(MAX_RETRY)) nxt = S_RECFG;
                else                              nxt = S_ROLLBACK;
            end
            S_PASS3:    nxt = S_CMP3;
            S_CMP3:     nxt = eq13 ? S_COMMIT : S_RECFG;
            S_RECFG:    if (reconfig_ack) nxt = S_ROLLBACK;
            S_ROLLBACK: nxt = S_IDLE;
            S_COMMIT:   if (!draining) nxt = S_IDLE;
            default:    nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= S_IDLE;
        else        cur <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q      <= '0;
            st_q      <= '0;
            res1_q    <= '0;
            res2_q    <= '0;
            res3_q    <= '0;
            draining  <= 1'b0;
            drain_idx <= '0;
            retry_q   <= '0;
            ckcnt_q   <= '0;
        end else begin
            if (draining) begin
                if (drain_idx == IW'(N_PE - 1)) draining <= 1'b0;
                else                            drain_idx <= drain_idx + 1'b1;
            end
            if (cur == S_IDLE && start) in_q <= blk_data;
            if (cur == S_PASS1) begin
                res1_q    <= pass_res;
                draining  <= 1'b1;
                drain_idx <= '0;
            end
            if (cur == S_PASS2) res2_q <= pass_res;
            if (cur == S_PASS3) res3_q <= pass_res;
            if (nxt == S_ROLLBACK || nxt == S_RECFG) draining <= 1'b0;
            if (cur == S_CMP12 && nxt == S_ROLLBACK) retry_q <= retry_q + 1'b1;
            if (cur != S_RECFG && nxt == S_RECFG)    retry_q <= '0;
            if (cur == S_ROLLBACK) begin
                st_q    <= ckpt_rdata;
                ckcnt_q <= '0;
            end
            if (commit_now) begin
                st_q    <= res1_q;
                retry_q <= '0;
                ckcnt_q <= (ckcnt_q == CKW'(CKPT_EVERY - 1)) ? '0 : ckcnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        fsm_status      = '0;
        fsm_status[cur] = 1'b1;
        res_valid       = draining;
        res_idx         = drain_idx;
        res_data        = res1_q[drain_idx*DW +: DW];
        commit          = commit_now;
        retract         = (cur == S_ROLLBACK);
        reconfig_req    = (cur == S_RECFG);
        ckpt_we         = commit_now && (ckcnt_q == CKW'(CKPT_EVERY - 1));
        ckpt_wdata      = res1_q;
    end
endmodule

// File: rtl/tfc_checker.sv
module tfc_checker #(
    parameter int unsigned N_PE = 4,
    localparam int unsigned IW  = $clog2(N_PE)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [8:0]    fsm_status,
    input logic          res_valid,
    input logic [IW-1:0] res_idx,
    input logic          commit,
    input logic          retract,
    input logic          reconfig_req,
    input logic          reconfig_ack,
    input logic          ckpt_we
);
    AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $countones(fsm_status) == 1); // R3
    AST_START_TO_PASS1: assert property (@(posedge clk) disable iff (!rst_n) fsm_status[0] && start |=> fsm_status[1]); // R2
    AST_PASS1_TO_PASS2: assert property (@(posedge clk) disable iff (!rst_n) fsm_status[1] |=> fsm_status[2]); // R3
    AST_STREAM_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n) $rose(res_valid) |-> res_idx == '0); // R5
    AST_COMMIT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) commit |=> fsm_status[0]); // R6
    AST_RETRACT_IN_ROLLBACK: assert property (@(posedge clk) disable iff (!rst_n) retract |-> fsm_status[6]); // R7
    AST_RETRACT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) retract |=> fsm_status[0]); // R7
    AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) reconfig_req && !reconfig_ack |=> reconfig_req); // R8
    AST_ACK_TO_ROLLBACK: assert property (@(posedge clk) disable iff (!rst_n) reconfig_req && reconfig_ack |=> retract); // R8
    AST_CKPT_WITH_COMMIT: assert property (@(posedge clk) disable iff (!rst_n) ckpt_we |-> commit); // R10
    AST_COMMIT_RETRACT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(commit && retract)); // R13
endmodule

bind temporal_fault_ctrl tfc_checker #(.N_PE(N_PE)) u_tfc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .fsm_status   (fsm_status),
    .res_valid    (res_valid),
    .res_idx      (res_idx),
    .commit       (commit),
    .retract      (retract),
    .reconfig_req (reconfig_req),
    .reconfig_ack (reconfig_ack),
    .ckpt_we      (ckpt_we)
);

// File: tb/test_temporal_fault_ctrl.sv
`timescale 1ns/1ps
module test_temporal_fault_ctrl;
    localparam int ST_IDLE = 0, ST_P1 = 1, ST_P2 = 2, ST_C12 = 3, ST_P3 = 4,
                   ST_C3 = 5, ST_RB = 6, ST_RW = 7, ST_CM = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] blk_data = '0;
    logic        res_valid, commit, retract, ckpt_we, reconfig_req;
    logic [1:0]  res_idx;
    logic [7:0]  res_data;
    logic [31:0] ckpt_wdata;
    logic [31:0] ckpt_mem;
    logic        inj_pulse = 1'b0, inj_stuck = 1'b0, reconfig_ack = 1'b0;
    logic [1:0]  inj_pe = '0;
    logic [7:0]  inj_val = '0;
    logic [8:0]  fsm_status;

    int checks = 0, failures = 0, cycles = 0;
    logic [7:0] st [4];
    logic [7:0] ck [4];
    int ckcnt = 0, retry = 0;

    always #2.5 clk = ~clk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ckpt_mem <= '0;
        else if (ckpt_we) ckpt_mem <= ckpt_wdata;
    end

    temporal_fault_ctrl i_temporal_fault_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_data(blk_data),
        .res_valid(res_valid), .res_idx(res_idx), .res_data(res_data),
        .commit(commit), .retract(retract), .ckpt_we(ckpt_we),
        .ckpt_wdata(ckpt_wdata), .ckpt_rdata(ckpt_mem),
        .inj_pulse(inj_pulse), .inj_stuck(inj_stuck), .inj_pe(inj_pe),
        .inj_val(inj_val), .reconfig_req(reconfig_req),
        .reconfig_ack(reconfig_ack), .fsm_status(fsm_status)
    );

    task automatic chk(input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic expc(input int s, input bit v, input int ix, input logic [7:0] dv,
                        input bit cm, input bit rt, input bit rq, input bit we,
                        input logic [31:0] wd);
        chk("R3 status", fsm_status, longint'(1) << s);
        chk("R5 res_valid", res_valid, v);
        if (v) begin
            chk("R5 res_idx", res_idx, ix);
            chk("R4 res_data", res_data, dv);
        end
        chk("R6 commit", commit, cm);
        chk("R7 retract", retract, rt);
        chk("R8 reconfig_req", reconfig_req, rq);
        chk("R10 ckpt_we", ckpt_we, we);
        if (we) chk("R10 ckpt_wdata", ckpt_wdata, wd);
        chk("R13 commit/retract exclusive", commit & retract, 0);
    endtask

    task automatic model_rollback();
        for (int i = 0; i < 4; i++) st[i] = ck[i];
        ckcnt = 0;
    endtask

    task automatic recfg_path(input string tag);
        @(negedge clk);
        chk(tag, fsm_status, longint'(1) << ST_RW);
        expc(ST_RW, 0, 0, 0, 0, 0, 1, 0, 0);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            expc(ST_RW, 0, 0, 0, 0, 0, 1, 0, 0);
        end
        reconfig_ack = 1'b1;
        inj_stuck    = 1'b0;
        @(negedge clk);
        reconfig_ack = 1'b0;
        expc(ST_RB, 0, 0, 0, 0, 1, 0, 0, 0);
        model_rollback();
        retry = 0;
        @(negedge clk);
        expc(ST_IDLE, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    // mode 0: clean (plus ignored start), 1: pulse in PASS1, 2: stuck, 3: pulse in PASS2
    task automatic run_block(input logic [31:0] d, input int mode);
        logic [7:0]  ex [4];
        logic [7:0]  p1 [4];
        logic [31:0] exw;
        logic [7:0]  sv;
        bit          we;
        for (int i = 0; i < 4; i++) begin
            ex[i] = d[i*8 +: 8] + st[i];
            p1[i] = ex[i];
        end
        exw = {ex[3], ex[2], ex[1], ex[0]};
        if (mode == 2) begin
            sv = ~ex[2];
            if (sv == ex[1]) sv = sv ^ 8'h01;
            p1[2]   = sv;
            inj_pe  = 2'd2;
            inj_val = sv;
        end else begin
            inj_pe  = 2'd3;
            inj_val = 8'h10;
        end
        @(negedge clk);
        blk_data = d;
        start    = 1'b1;
        if (mode == 2) inj_stuck = 1'b1;
        @(negedge clk);
        start = 1'b0;
        expc(ST_P1, 0, 0, 0, 0, 0, 0, 0, 0);
        if (mode == 1) inj_pulse = 1'b1;
        @(negedge clk);
        inj_pulse = 1'b0;
        expc(ST_P2, 1, 0, p1[0], 0, 0, 0, 0, 0);
        if (mode == 0) begin
            start    = 1'b1;
            blk_data = ~d;
        end
        if (mode == 3) inj_pulse = 1'b1;
        @(negedge clk);
        start     = 1'b0;
        inj_pulse = 1'b0;
        blk_data  = d;
        expc(ST_C12, 1, 1, p1[1], 0, 0, 0, 0, 0);
        if (mode == 0) chk("R2 late start ignored", fsm_status, longint'(1) << ST_C12);
        if (mode == 1 || mode == 3) begin
            if (retry == 3) begin
                recfg_path("R9 escalation to reconfig");
            end else begin
                retry++;
                @(negedge clk);
                expc(ST_RB, 0, 0, 0, 0, 1, 0, 0, 0);
                model_rollback();
                @(negedge clk);
                expc(ST_IDLE, 0, 0, 0, 0, 0, 0, 0, 0);
            end
            return;
        end
        @(negedge clk);
        expc(ST_P3, 1, 2, p1[2], 0, 0, 0, 0, 0);
        @(negedge clk);
        expc(ST_C3, 1, 3, p1[3], 0, 0, 0, 0, 0);
        if (mode == 2) begin
            recfg_path("R11 R12 stuck element seen by rotated pass");
            return;
        end
        we = (ckcnt == 1);
        @(negedge clk);
        expc(ST_CM, 0, 0, 0, 1, 0, 0, we, exw);
        for (int i = 0; i < 4; i++) st[i] = ex[i];
        retry = 0;
        if (we) begin
            for (int i = 0; i < 4; i++) ck[i] = ex[i];
            ckcnt = 0;
        end else begin
            ckcnt++;
        end
        @(negedge clk);
        expc(ST_IDLE, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                checks++;
                failures++;
                $display("FAIL watchdog R3 actual=timeout expected=completion");
                finish_run();
            end
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            st[i] = '0;
            ck[i] = '0;
        end
        repeat (3) @(negedge clk);
        chk("R1 reset status", fsm_status, 9'h001);
        expc(ST_IDLE, 0, 0, 0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", fsm_status, 9'h001);
        expc(ST_IDLE, 0, 0, 0, 0, 0, 0, 0, 0);

        run_block(32'h04_03_02_01, 0);   // R2 R4 R6
        run_block(32'h10_20_30_40, 0);   // R10 checkpoint write
        run_block(32'h0A_0B_0C_0D, 0);
        run_block(32'h55_66_77_88, 1);   // R7 transient rollback
        run_block(32'h01_01_01_01, 0);   // R7 restored state, R10 count restarted
        run_block(32'h21_43_65_87, 2);   // R8 R11 R12 persistent
        run_block(32'h11_22_33_44, 0);
        run_block(32'h99_88_77_66, 1);   // R9 retries 1..3
        run_block(32'h99_88_77_66, 3);
        run_block(32'h99_88_77_66, 1);
        run_block(32'h99_88_77_66, 1);   // R9 fourth failure escalates
        run_block(32'hDE_AD_BE_EF, 3);   // retry count cleared by reconfig
        run_block(32'hFF_FF_FF_FF, 0);   // R4 wrap-around
        run_block(32'h12_34_56_78, 0);
        run_block(32'h00_00_00_00, 0);
        finish_run();
    end
endmodule